// File: doc/BRIEF.md
# Real-Time Clock Register File with Interrupt Flags

This block is the software-visible side of a real-time clock. A processor reaches 128 bytes through two addresses: a write to the even address latches a 7-bit pointer, and an access to the odd address reads or writes the byte that pointer selects. Four of those bytes are control and status registers with side effects. Three more hold alarm values. All remaining bytes are plain storage.

The time counter and the rate divider sit outside the block. They send three single-cycle strobes: update start, update done, and periodic tick. They also supply the current seconds, minutes and hours for the alarm comparison. In return they read back the control fields from the `reg_a` and `reg_b` outputs. The block gathers alarm, periodic and update-ended events into a flag byte that clears when read, and drives one active-high interrupt line.

The pointer selects these bytes. Index 10 is the rate/status register, 11 is the control register, 12 is the flag register and 13 is the validity register. Indices 1, 3 and 5 hold the seconds, minutes and hours alarms.

Top module: `rtc_regfile`

## Requirements
- R1: A write with `bus_addr`=0 stores `bus_wdata[6:0]` as the pointer. An access with `bus_addr`=1 reads or writes the selected byte. All indices except 10 to 13 are plain read/write storage, including the alarm bytes at 1, 3 and 5 and every index from 14 up.
- R2: A read with `bus_addr`=0 returns 0xFF.
- R3: After `rst_n` is released, index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00, index 13 reads 0x80, and `irq` is low.
- R4: Bit 7 of index 10 is the update-in-progress flag, and software cannot write it: a write changes only bits 6:0. `upd_start` sets the flag unless bit 7 of index 11 is set. `upd_done` clears it.
- R5: Writing index 11 with bit 7 set clears the update-in-progress flag. The value stored in index 11 then has bit 4 forced to 0.
- R6: Writes to index 12 and index 13 have no effect. Index 13 always reads 0x80.
- R7: A read of index 12 returns the current flags. One cycle later the flags are 0x00 and `irq` is low, except for flags raised by an event in the same cycle as the read. Those flags survive the clear.
- R8: On `upd_done`, the block compares each alarm byte with its current time value. An alarm byte matches when its bits 7:6 are 11 or when it equals the time value. If all three bytes match and bit 5 of index 11 is set, bits 7 and 5 of index 12 are set and `irq` rises.
- R9: Every `upd_done` sets bit 4 of index 12. If bit 4 of index 11 is also set, bit 7 of index 12 is set as well and `irq` rises.
- R10: A `per_tick` sets bits 7 and 6 of index 12 and raises `irq` only when bit 6 of index 11 is set. Otherwise the tick has no effect.
- R11: `soft_rst` clears bits 6, 5 and 3 of index 11 and bits 7:4 of index 12, and drives `irq` low. All other bits of index 11 are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| soft_rst | input | 1 | Synchronous system reset pulse |
| bus_sel | input | 1 | Bus access strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = pointer port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| upd_start | input | 1 | Time update begins |
| upd_done | input | 1 | Time update finished, alarm check |
| per_tick | input | 1 | Periodic rate event |
| cur_sec | input | 8 | Current seconds for alarm compare |
| cur_min | input | 8 | Current minutes for alarm compare |
| cur_hour | input | 8 | Current hours for alarm compare |
| reg_a | output | 8 | Contents of index 10 |
| reg_b | output | 8 | Contents of index 11 |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a read of the flag register in the same cycle that a new event arrives. The clear and the new flags then collide, and the new flags must survive. The stimulus first fills the flags with a periodic tick. It then issues the flag read and the next tick from one task in the same cycle, samples the data returned, and reads the register again afterwards. A second difficult case is an update start that comes while the freeze bit (bit 7 of index 11) is set. This is reached by writing the control register with bit 7 set and then pulsing `upd_start`.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int IDX_W  = 7;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int N_ALM  = 3;

    localparam logic [IDX_W-1:0] IDX_A     = 7'd10;
    localparam logic [IDX_W-1:0] IDX_B     = 7'd11;
    localparam logic [IDX_W-1:0] IDX_C     = 7'd12;
    localparam logic [IDX_W-1:0] IDX_D     = 7'd13;
    localparam logic [IDX_W-1:0] IDX_ALM_S = 7'd1;
    localparam logic [IDX_W-1:0] IDX_ALM_M = 7'd3;
    localparam logic [IDX_W-1:0] IDX_ALM_H = 7'd5;

    localparam logic [DATA_W-1:0] A_RESET  = 8'h26;
    localparam logic [DATA_W-1:0] B_RESET  = 8'h02;
    localparam logic [DATA_W-1:0] D_VALUE  = 8'h80;

    // bit positions
    localparam int A_BUSY = 7;
    localparam int B_FRZ  = 7;
    localparam int B_PER  = 6;
    localparam int B_ALM  = 5;
    localparam int B_UPD  = 4;
    localparam int B_SQW  = 3;
    localparam int C_ANY  = 7;
    localparam int C_PER  = 6;
    localparam int C_ALM  = 5;
    localparam int C_UPD  = 4;

    typedef struct packed {
        logic [IDX_W-1:0]              ptr;
        logic [DATA_W-1:0]             a;
        logic [DATA_W-1:0]             b;
        logic [DATA_W-1:0]             c;
        logic [N_ALM-1:0][DATA_W-1:0]  alm;
        logic                          irq;
    } rf_state_t;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int N = 3,
    parameter int W = 8
) (
    input  logic [N-1:0][W-1:0] alarm,
    input  logic [N-1:0][W-1:0] now,
    output logic                hit
);
    logic [N-1:0] field_ok;

    for (genvar i = 0; i < N; i++) begin : g_field
        // top two bits both set: wildcard
        assign field_ok[i] = (&alarm[i][W-1:W-2]) || (alarm[i] == now[i]);
    end

    assign hit = &field_ok;
endmodule

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
    parameter int DEPTH = 128,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              upd_start,
    input  logic              upd_done,
    input  logic              per_tick,
    input  logic [DATA_W-1:0] cur_sec,
    input  logic [DATA_W-1:0] cur_min,
    input  logic [DATA_W-1:0] cur_hour,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic              irq
);
    rf_state_t q, d;

    logic wr_ptr, wr_dat, rd_dat, rd_flags;
    logic is_ctl, alm_sel;
    logic [1:0] alm_slot;
    logic alarm_hit;
    logic ram_we;
    logic [DATA_W-1:0] ram_rdata;
    logic [N_ALM-1:0][DATA_W-1:0] now_vec;

    assign wr_ptr   = bus_sel &  bus_wr & ~bus_addr;
    assign wr_dat   = bus_sel &  bus_wr &  bus_addr;
    assign rd_dat   = bus_sel & ~bus_wr &  bus_addr;
    assign rd_flags = rd_dat & (q.ptr == IDX_C);
    assign is_ctl   = (q.ptr >= IDX_A) && (q.ptr <= IDX_D);
    assign now_vec  = {cur_hour, cur_min, cur_sec};

    always_comb begin
        alm_sel  = 1'b1;
        alm_slot = 2'd0;
        case (q.ptr)
            IDX_ALM_S: alm_slot = 2'd0;
            IDX_ALM_M: alm_slot = 2'd1;
            IDX_ALM_H: alm_slot = 2'd2;
            default:   alm_sel  = 1'b0;
        endcase
    end

    assign ram_we = wr_dat & ~is_ctl & ~alm_sel;

    rtc_scratch_ram #(.DEPTH(DEPTH), .W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (q.ptr),
        .wdata (bus_wdata),
        .raddr (q.ptr),
        .rdata (ram_rdata)
    );

    rtc_alarm_match #(.N(N_ALM), .W(DATA_W)) u_alarm (
        .alarm (q.alm),
        .now   (now_vec),
        .hit   (alarm_hit)
    );

    // read mux
    always_comb begin
        if (!bus_addr)            bus_rdata = '1;
        else if (q.ptr == IDX_A)  bus_rdata = q.a;
        else if (q.ptr == IDX_B)  bus_rdata = q.b;
        else if (q.ptr == IDX_C)  bus_rdata = q.c;
        else if (q.ptr == IDX_D)  bus_rdata = D_VALUE;
        else if (alm_sel)         bus_rdata = q.alm[alm_slot];
        else                      bus_rdata = ram_rdata;
    end

    // next state
    always_comb begin
        d = q;
        if (wr_ptr) d.ptr = bus_wdata[IDX_W-1:0];
        if (wr_dat) begin
            if (q.ptr == IDX_A) begin
                d.a = {q.a[A_BUSY], bus_wdata[A_BUSY-1:0]};
            end else if (q.ptr == IDX_B) begin
                d.b = bus_wdata;
                if (bus_wdata[B_FRZ]) begin
                    d.b[B_UPD]  = 1'b0;
                    d.a[A_BUSY] = 1'b0;
                end
            end else if (alm_sel) begin
                d.alm[alm_slot] = bus_wdata;
            end
        end
        if (rd_flags) begin
            d.c   = '0;
            d.irq = 1'b0;
        end
        if (upd_start && !d.b[B_FRZ]) d.a[A_BUSY] = 1'b1;
        if (upd_done) begin
            d.a[A_BUSY] = 1'b0;
            d.c[C_UPD]  = 1'b1;
            if (q.b[B_ALM] && alarm_hit) begin
                d.c[C_ANY] = 1'b1;
                d.c[C_ALM] = 1'b1;
                d.irq      = 1'b1;
            end
            if (q.b[B_UPD]) begin
                d.c[C_ANY] = 1'b1;
                d.irq      = 1'b1;
            end
        end
        if (per_tick && q.b[B_PER]) begin
            d.c[C_ANY] = 1'b1;
            d.c[C_PER] = 1'b1;
            d.irq      = 1'b1;
        end
        if (soft_rst) begin
            d.b[B_PER] = 1'b0;
            d.b[B_ALM] = 1'b0;
            d.b[B_SQW] = 1'b0;
            d.c[C_ANY:C_UPD] = '0;
            d.irq      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.a   <= A_RESET;
            q.b   <= B_RESET;
        end else begin
            q <= d;
        end
    end

    assign reg_a = q.a;
    assign reg_b = q.b;
    assign irq   = q.irq;

    // R4: software write never moves the busy flag
    a_r4_busy_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && q.ptr == IDX_A && !upd_start && !upd_done && !soft_rst)
        |=> (q.a[A_BUSY] == $past(q.a[A_BUSY])));

    // R5: freeze write leaves update-interrupt enable and busy flag low
    a_r5_freeze_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && q.ptr == IDX_B && bus_wdata[B_FRZ])
        |=> (!q.b[B_UPD] && !q.a[A_BUSY]));

    // R6: flag register unaffected by writes
    a_r6_flags_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && q.ptr == IDX_C && !upd_done && !per_tick && !soft_rst)
        |=> $stable(q.c));

    // R7: a flag read with no competing event empties the flags
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !upd_done && !per_tick)
        |=> (q.c == '0 && !irq));

    // R9: the interrupt line is never high without the summary flag
    a_r9_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> q.c[C_ANY]);

    // R11: system reset drops the line and event enables
    a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!irq && q.c[C_ANY:C_UPD] == '0 && !q.b[B_PER] && !q.b[B_ALM]));
endmodule

// File: tb/rtc_regfile_tb.sv
module rtc_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic upd_start = 1'b0, upd_done = 1'b0, per_tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [7:0] reg_a, reg_b;
    logic irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_start(upd_start), .upd_done(upd_done), .per_tick(per_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .reg_a(reg_a), .reg_b(reg_b), .irq(irq)
    );

    // {op, index, data, expected}: op 0 = write byte, 1 = read and compare
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 8'h0A, 8'h00, 8'h26},   // R3
        {1'b1, 8'h0B, 8'h00, 8'h02},   // R3
        {1'b1, 8'h0C, 8'h00, 8'h00},   // R3
        {1'b1, 8'h0D, 8'h00, 8'h80},   // R3
        {1'b0, 8'h20, 8'h5A, 8'h00},   // R1
        {1'b1, 8'h20, 8'h00, 8'h5A},
        {1'b0, 8'h7F, 8'h33, 8'h00},   // R1
        {1'b1, 8'h7F, 8'h00, 8'h33},
        {1'b0, 8'h01, 8'h11, 8'h00},   // R1 alarm byte
        {1'b1, 8'h01, 8'h00, 8'h11},
        {1'b0, 8'h0E, 8'hC3, 8'h00},   // R1
        {1'b1, 8'h0E, 8'h00, 8'hC3},
        {1'b0, 8'h0D, 8'h00, 8'h00},   // R6
        {1'b1, 8'h0D, 8'h00, 8'h80},
        {1'b0, 8'h0C, 8'hFF, 8'h00},   // R6
        {1'b1, 8'h0C, 8'h00, 8'h00},
        {1'b0, 8'h0A, 8'hAB, 8'h00},   // R4
        {1'b1, 8'h0A, 8'h00, 8'h2B},
        {1'b0, 8'h0A, 8'h26, 8'h00},
        {1'b1, 8'h0A, 8'h00, 8'h26},
        {1'b1, 8'h20, 8'h00, 8'h5A},
        {1'b1, 8'h7F, 8'h00, 8'h33}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic a, input logic wr, input logic [7:0] dat);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = a; bus_wr = wr; bus_wdata = dat;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] dat);
        cycle(1'b0, 1'b1, idx);
        cycle(1'b1, 1'b1, dat);
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] val);
        cycle(1'b0, 1'b1, idx);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = 1'b1; bus_wr = 1'b0;
        #1 val = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: upd_start = 1'b1;
            1: upd_done  = 1'b1;
            2: per_tick  = 1'b1;
            default: soft_rst = 1'b1;
        endcase
        @(negedge clk);
        upd_start = 1'b0; upd_done = 1'b0; per_tick = 1'b0; soft_rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        check("R3 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][24]) begin
                rd_reg(VEC[i][23:16], v);
                check("R1/R3/R4/R6 vector", v, VEC[i][7:0]);
            end else begin
                wr_reg(VEC[i][23:16], VEC[i][15:8]);
            end
        end

        // R1: pointer masked to 7 bits (0xA0 -> 0x20)
        cycle(1'b0, 1'b1, 8'hA0);
        @(negedge clk); bus_sel = 1'b1; bus_addr = 1'b1; bus_wr = 1'b0;
        #1 check("R1 pointer mask", bus_rdata, 8'h5A);
        @(negedge clk); bus_sel = 1'b0;
        // R2: pointer port reads 0xFF
        @(negedge clk); bus_sel = 1'b1; bus_addr = 1'b0; bus_wr = 1'b0;
        #1 check("R2 pointer read", bus_rdata, 8'hFF);
        @(negedge clk); bus_sel = 1'b0;

        // R4: busy flag by events only
        pulse(0);
        rd_reg(8'h0A, v); check("R4 busy set", v, 8'hA6);
        wr_reg(8'h0A, 8'h26);
        rd_reg(8'h0A, v); check("R4 busy kept on write", v, 8'hA6);
        pulse(1);
        rd_reg(8'h0A, v); check("R4 busy cleared", v, 8'h26);
        // R9: flag without interrupt enable
        check("R9 no irq", {7'd0, irq}, 8'h00);
        rd_reg(8'h0C, v); check("R9 update flag", v, 8'h10);
        rd_reg(8'h0C, v); check("R7 cleared", v, 8'h00);

        // R5: freeze write
        pulse(0);
        wr_reg(8'h0B, 8'h92);
        rd_reg(8'h0B, v); check("R5 enable forced low", v, 8'h82);
        rd_reg(8'h0A, v); check("R5 busy cleared", v, 8'h26);
        pulse(0);
        rd_reg(8'h0A, v); check("R4 start ignored in freeze", v, 8'h26);

        // R9 with enable
        wr_reg(8'h0B, 8'h12);
        pulse(1);
        check("R9 irq high", {7'd0, irq}, 8'h01);
        rd_reg(8'h0C, v); check("R9 flags", v, 8'h90);
        check("R7 irq low after read", {7'd0, irq}, 8'h00);

        // R8: alarm with minute wildcard
        wr_reg(8'h01, 8'h30); wr_reg(8'h03, 8'hC0); wr_reg(8'h05, 8'h07);
        wr_reg(8'h0B, 8'h22);
        cur_sec = 8'h30; cur_min = 8'h15; cur_hour = 8'h07;
        pulse(1);
        check("R8 irq high", {7'd0, irq}, 8'h01);
        rd_reg(8'h0C, v); check("R8 alarm flags", v, 8'hB0);
        cur_sec = 8'h31;
        pulse(1);
        check("R8 mismatch no irq", {7'd0, irq}, 8'h00);
        rd_reg(8'h0C, v); check("R8 mismatch flags", v, 8'h10);

        // R10: periodic gating
        wr_reg(8'h0B, 8'h02);
        pulse(2);
        check("R10 disabled irq", {7'd0, irq}, 8'h00);
        rd_reg(8'h0C, v); check("R10 disabled flags", v, 8'h00);
        wr_reg(8'h0B, 8'h42);
        pulse(2);
        check("R10 irq", {7'd0, irq}, 8'h01);

        // R7: read coinciding with a new tick
        cycle(1'b0, 1'b1, 8'h0C);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = 1'b1; bus_wr = 1'b0; per_tick = 1'b1;
        #1 check("R10 flags", bus_rdata, 8'hC0);
        @(negedge clk);
        bus_sel = 1'b0; per_tick = 1'b0;
        check("R7 irq survives", {7'd0, irq}, 8'h01);
        rd_reg(8'h0C, v); check("R7 flags survive", v, 8'hC0);
        rd_reg(8'h0C, v); check("R7 flags clear", v, 8'h00);

        // R11: system reset
        wr_reg(8'h0B, 8'h6A);
        pulse(2);
        check("R11 pre irq", {7'd0, irq}, 8'h01);
        pulse(3);
        check("R11 irq low", {7'd0, irq}, 8'h00);
        rd_reg(8'h0B, v); check("R11 control", v, 8'h02);
        rd_reg(8'h0C, v); check("R11 flags", v, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule